// File: doc/BRIEF.md
# CAN Standard Frame Transmitter with Bus Arbitration

This block sends one standard-format (11-bit identifier) CAN frame onto a wired-AND bus model. The frame contents arrive as parallel fields: identifier, remote flag, length code and up to eight data bytes. A start strobe latches them. From then on the block puts out one bit per bit-rate tick. It inserts stuff bits, appends a 15-bit CRC and finishes with the delimiter, acknowledge, end-of-frame and interframe-space bits.

While the identifier and remote bits are on the wire, the block reads the bus back at every tick. If it drives recessive (1) and sees dominant (0), another node owns the bus. The block then lets go at once: it drives recessive, drops busy and raises an arbitration-lost flag. It also captures whether a receiver acknowledged the frame, and pulses done after the final interframe-space bit.

Top module: `can_frame_tx`

## Requirements
- R1: After reset, tx_o is recessive (1) and busy_o, done_o, arb_lost_o and ack_o are all 0. Whenever busy_o is 0, tx_o is 1.
- R2: start_i is taken only while busy_o is 0. Taking it latches the request fields and drives the dominant start-of-frame bit on the next cycle. A start_i pulse while busy_o is 1 changes nothing, and request inputs that change after acceptance do not affect the frame.
- R3: tx_o changes only at a clock edge where tick_i is 1, or at the edge that accepts start_i. While the block is idle, ticks leave tx_o at 1.
- R4: The unstuffed bit order is as follows: start-of-frame 0, then id_i[10] down to id_i[0], then rtr_i, then a 0 identifier-extension bit, then a 0 reserved bit, then dlc_i[3] down to dlc_i[0], then the data bits. Data byte k is data_i[8k+7:8k], bytes go out in ascending k and each byte goes out bit 7 first.
- R5: A data frame carries min(dlc_i, 8) bytes, so length codes 9 to 15 send eight bytes. A remote frame (rtr_i = 1) carries no data bits for any length code.
- R6: After the data comes a 15-bit CRC, most significant bit first. It covers the unstuffed bits from start-of-frame through the last data bit, with generator 0x4599 and initial value 0. Each bit b updates the register as c = (c << 1) xor (b xor c[14] ? 0x4599 : 0).
- R7: From start-of-frame through the last CRC bit, once five consecutive wire bits are equal, the next wire bit is their complement. A stuff bit counts toward the next run but does not enter the CRC. A stuff bit is still inserted after the last CRC bit when the run ends there.
- R8: After the CRC (and any trailing stuff bit) the block drives 13 recessive bits with no stuffing: the CRC delimiter, the acknowledge slot, the acknowledge delimiter, seven end-of-frame bits and three interframe-space bits.
- R9: At a tick that ends a non-stuff identifier or remote bit, if tx_o is 1 and rx_i is 0, the block sets arb_lost_o and drops busy_o on that edge, drives tx_o at 1 from then on, and does not pulse done_o. arb_lost_o stays 1 until the next accepted start.
- R10: If the bus level matches the driven level in every arbitration bit, transmission continues to the end of the frame and arb_lost_o stays 0. A competitor losing on a dominant bit sent by this block counts as matching.
- R11: ack_o takes the complement of rx_i sampled at the tick that ends the acknowledge slot, and holds that value until the next accepted start.
- R12: done_o is a one-cycle pulse at the edge of the tick that ends the last interframe-space bit, and busy_o drops on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken while idle |
| id_i | input | 11 | Frame identifier |
| rtr_i | input | 1 | 1 = remote frame, 0 = data frame |
| dlc_i | input | 4 | Length code |
| data_i | input | 8*MAX_BYTES | Payload, byte k in bits [8k+7:8k] |
| tick_i | input | 1 | One pulse per bit time |
| rx_i | input | 1 | Sampled bus level |
| tx_o | output | 1 | Driven bus level, 1 = recessive |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at end of frame |
| arb_lost_o | output | 1 | Arbitration lost on the last frame |
| ack_o | output | 1 | Acknowledge seen on the last frame |

## Verification
The hardest case to reach from the ports is losing arbitration on a chosen identifier bit, especially one that follows a stuff bit, because the loss depends on a second node's bit stream agreeing with this one up to that exact position. The bench builds the competitor's complete stuffed frame with the same arithmetic it uses for the expected stream, and combines the two on a wired-AND bus. It finds the first position where the streams differ and predicts whether this block loses or wins there. The sweep also uses an all-zero identifier and all-zero or all-one payloads, so stuff bits fall inside the arbitration field and right after the final CRC bit.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
    localparam int ID_W  = 11;
    localparam int CRC_W = 15;
    localparam int DLC_W = 4;
    localparam int EOF_LEN = 7;
    localparam int IFS_LEN = 3;

    typedef enum logic [3:0] {
        PH_IDLE, PH_SOF, PH_ID, PH_RTR, PH_IDE, PH_R0, PH_DLC, PH_DATA,
        PH_CRC, PH_CRCDEL, PH_ACK, PH_ACKDEL, PH_EOF, PH_IFS
    } phase_e;
endpackage

// File: rtl/can_tx_crc15.sv
module can_tx_crc15 import can_tx_pkg::*; #(
    parameter logic [CRC_W-1:0] POLY = 15'h4599
) (
    input  logic             en_i,
    input  logic             bit_i,
    input  logic [CRC_W-1:0] crc_i,
    output logic [CRC_W-1:0] crc_o
);
    logic fb;
    always_comb begin
        fb    = bit_i ^ crc_i[CRC_W-1];
        crc_o = crc_i;
        if (en_i)
            crc_o = {crc_i[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/can_tx_stuff_track.sv
module can_tx_stuff_track #(
    parameter int RUN_LEN = 5,
    parameter int RUN_W   = $clog2(RUN_LEN + 1)
) (
    input  logic             bit_i,
    input  logic             last_i,
    input  logic [RUN_W-1:0] run_i,
    output logic [RUN_W-1:0] run_o,
    output logic             hit_o
);
    always_comb begin
        if (run_i != '0 && bit_i == last_i)
            run_o = run_i + RUN_W'(1);
        else
            run_o = RUN_W'(1);
        hit_o = (run_o == RUN_W'(RUN_LEN));
    end
endmodule

// File: rtl/can_tx_bitsel.sv
module can_tx_bitsel import can_tx_pkg::*; #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 7
) (
    input  phase_e            ph_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic              rtr_i,
    input  logic [DLC_W-1:0]  dlc_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CRC_W-1:0]  crc_i,
    output logic              bit_o
);
    // payload reordered so wire order runs from the top bit down
    logic [DATA_W-1:0] stream;
    for (genvar i = 0; i < DATA_W; i++) begin : g_order
        assign stream[DATA_W-1-i] = data_i[8*(i/8) + 7 - (i%8)];
    end

    logic [ID_W-1:0]   id_sh;
    logic [DLC_W-1:0]  dlc_sh;
    logic [DATA_W-1:0] dat_sh;
    logic [CRC_W-1:0]  crc_sh;

    always_comb begin
        id_sh  = id_i   << idx_i;
        dlc_sh = dlc_i  << idx_i;
        dat_sh = stream << idx_i;
        crc_sh = crc_i  << idx_i;
        case (ph_i)
            PH_SOF, PH_IDE, PH_R0: bit_o = 1'b0;
            PH_ID:   bit_o = id_sh[ID_W-1];
            PH_RTR:  bit_o = rtr_i;
            PH_DLC:  bit_o = dlc_sh[DLC_W-1];
            PH_DATA: bit_o = dat_sh[DATA_W-1];
            PH_CRC:  bit_o = crc_sh[CRC_W-1];
            default: bit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx import can_tx_pkg::*; #(
    parameter int               MAX_BYTES = 8,
    parameter int               STUFF_LEN = 5,
    parameter logic [CRC_W-1:0] CRC_POLY  = 15'h4599
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [ID_W-1:0]        id_i,
    input  logic                   rtr_i,
    input  logic [DLC_W-1:0]       dlc_i,
    input  logic [8*MAX_BYTES-1:0] data_i,
    input  logic                   tick_i,
    input  logic                   rx_i,
    output logic                   tx_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   arb_lost_o,
    output logic                   ack_o
);
    localparam int DATA_W = 8 * MAX_BYTES;
    localparam int IDX_W  = $clog2(DATA_W + 1);
    localparam int RUN_W  = $clog2(STUFF_LEN + 1);

    typedef struct packed {
        phase_e            ph;
        logic [IDX_W-1:0]  idx;
        logic              tx;
        logic              stf;
        logic [RUN_W-1:0]  run;
        logic              last;
        logic [CRC_W-1:0]  crc;
        logic [ID_W-1:0]   id;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              lost;
        logic              ack;
    } st_t;

    st_t s_q, s_d;

    logic             in_region, in_arb, crc_en, stuff_hit, raw_bit;
    logic [CRC_W-1:0] crc_nx;
    logic [RUN_W-1:0] run_nx;
    logic [DLC_W-1:0] nbytes;
    logic [IDX_W-1:0] nbits, nidx;
    phase_e           nph;

    assign in_region = (s_q.ph >= PH_SOF) && (s_q.ph <= PH_CRC);
    assign in_arb    = (s_q.ph == PH_ID) || (s_q.ph == PH_RTR);
    assign crc_en    = tick_i && !s_q.stf && (s_q.ph >= PH_SOF) && (s_q.ph <= PH_DATA);

    can_tx_crc15 #(.POLY(CRC_POLY)) u_crc (
        .en_i(crc_en), .bit_i(s_q.tx), .crc_i(s_q.crc), .crc_o(crc_nx)
    );

    can_tx_stuff_track #(.RUN_LEN(STUFF_LEN), .RUN_W(RUN_W)) u_stuff (
        .bit_i(s_q.tx), .last_i(s_q.last), .run_i(s_q.run),
        .run_o(run_nx), .hit_o(stuff_hit)
    );

    can_tx_bitsel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
        .ph_i(nph), .idx_i(nidx), .id_i(s_q.id), .rtr_i(s_q.rtr),
        .dlc_i(s_q.dlc), .data_i(s_q.data), .crc_i(crc_nx), .bit_o(raw_bit)
    );

    // position of the next unstuffed bit
    always_comb begin
        if (s_q.rtr)
            nbytes = '0;
        else if (s_q.dlc > DLC_W'(MAX_BYTES))
            nbytes = DLC_W'(MAX_BYTES);
        else
            nbytes = s_q.dlc;
        nbits = IDX_W'(nbytes) << 3;

        nph  = s_q.ph;
        nidx = s_q.idx + IDX_W'(1);
        case (s_q.ph)
            PH_SOF: begin nph = PH_ID; nidx = '0; end
            PH_ID:  if (s_q.idx == IDX_W'(ID_W-1)) begin nph = PH_RTR; nidx = '0; end
            PH_RTR: begin nph = PH_IDE; nidx = '0; end
            PH_IDE: begin nph = PH_R0;  nidx = '0; end
            PH_R0:  begin nph = PH_DLC; nidx = '0; end
            PH_DLC: if (s_q.idx == IDX_W'(DLC_W-1)) begin
                        nph  = (nbits == '0) ? PH_CRC : PH_DATA;
                        nidx = '0;
                    end
            PH_DATA: if (s_q.idx == nbits - IDX_W'(1)) begin nph = PH_CRC; nidx = '0; end
            PH_CRC:  if (s_q.idx == IDX_W'(CRC_W-1)) begin nph = PH_CRCDEL; nidx = '0; end
            PH_CRCDEL: begin nph = PH_ACK;    nidx = '0; end
            PH_ACK:    begin nph = PH_ACKDEL; nidx = '0; end
            PH_ACKDEL: begin nph = PH_EOF;    nidx = '0; end
            PH_EOF:  if (s_q.idx == IDX_W'(EOF_LEN-1)) begin nph = PH_IFS; nidx = '0; end
            PH_IFS:  if (s_q.idx == IDX_W'(IFS_LEN-1)) begin nph = PH_IDLE; nidx = '0; end
            default: begin nph = PH_IDLE; nidx = '0; end
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.ph == PH_IDLE) begin
            if (start_i) begin
                s_d.ph   = PH_SOF;
                s_d.idx  = '0;
                s_d.tx   = 1'b0;
                s_d.stf  = 1'b0;
                s_d.run  = '0;
                s_d.last = 1'b1;
                s_d.crc  = '0;
                s_d.id   = id_i;
                s_d.rtr  = rtr_i;
                s_d.dlc  = dlc_i;
                s_d.data = data_i;
                s_d.lost = 1'b0;
                s_d.ack  = 1'b0;
            end
        end else if (tick_i) begin
            if (in_arb && !s_q.stf && s_q.tx && !rx_i) begin
                s_d.ph   = PH_IDLE;
                s_d.idx  = '0;
                s_d.tx   = 1'b1;
                s_d.lost = 1'b1;
            end else begin
                if (in_region) begin
                    s_d.run  = run_nx;
                    s_d.last = s_q.tx;
                end
                s_d.crc = crc_nx;
                if (s_q.ph == PH_ACK)
                    s_d.ack = !rx_i;
                if (in_region && stuff_hit) begin
                    s_d.stf = 1'b1;
                    s_d.tx  = !s_q.tx;
                end else begin
                    s_d.stf  = 1'b0;
                    s_d.ph   = nph;
                    s_d.idx  = nidx;
                    s_d.tx   = raw_bit;
                    s_d.done = (nph == PH_IDLE);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.tx   <= 1'b1;
            s_q.last <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_o       = s_q.tx;
    assign busy_o     = (s_q.ph != PH_IDLE);
    assign done_o     = s_q.done;
    assign arb_lost_o = s_q.lost;
    assign ack_o      = s_q.ack;

    // R1
    idle_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);
    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(start_i && !busy_o)) |=> $stable(tx_o));
    // R2
    busy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(s_q.id) && $stable(s_q.dlc) && $stable(s_q.data)));
    // R9
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost_o) |-> (!busy_o && tx_o && !done_o));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/can_frame_tx_bench.sv
`timescale 1ns/1ps
module can_frame_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic        other = 1'b1;
    logic [10:0] id = '0;
    logic        rtr = 1'b0;
    logic [3:0]  dlc = '0;
    logic [63:0] data = '0;
    logic        tx, busy, done, lost, ack, rx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    assign rx = tx & other;

    always #10 clk = ~clk;

    can_frame_tx u_can_frame_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start), .id_i(id), .rtr_i(rtr),
        .dlc_i(dlc), .data_i(data), .tick_i(tick), .rx_i(rx), .tx_o(tx),
        .busy_o(busy), .done_o(done), .arb_lost_o(lost), .ack_o(ack)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected wire stream built from the requirements
    task automatic build(input logic [10:0] fid, input logic frtr, input logic [3:0] fdlc,
                         input logic [63:0] fdata, output logic [159:0] s,
                         output int len, output int ackpos);
        logic [127:0] r;
        logic [14:0]  c;
        logic         b, prev, fb;
        int n, nb, run;
        r = '0;
        n = 0;
        r[n] = 1'b0; n++;
        for (int i = 10; i >= 0; i--) begin r[n] = fid[i]; n++; end
        r[n] = frtr; n++;
        r[n] = 1'b0; n++;
        r[n] = 1'b0; n++;
        for (int i = 3; i >= 0; i--) begin r[n] = fdlc[i]; n++; end
        nb = frtr ? 0 : ((fdlc > 4'd8) ? 8 : int'(fdlc));
        for (int k = 0; k < nb; k++)
            for (int j = 7; j >= 0; j--) begin r[n] = fdata[8*k + j]; n++; end
        c = '0;
        for (int i = 0; i < n; i++) begin
            fb = r[i] ^ c[14];
            c  = {c[13:0], 1'b0} ^ (fb ? 15'h4599 : 15'h0);
        end
        for (int i = 14; i >= 0; i--) begin r[n] = c[i]; n++; end
        s = '1;
        len = 0;
        run = 0;
        prev = 1'b1;
        for (int i = 0; i < n; i++) begin
            b = r[i];
            s[len] = b; len++;
            if (run > 0 && b == prev) run++; else run = 1;
            prev = b;
            if (run == 5) begin
                s[len] = ~b; len++;
                prev = ~b;
                run = 1;
            end
        end
        ackpos = len + 1;
        len = len + 13;
    endtask

    task automatic run_frame(input logic [10:0] fid, input logic frtr, input logic [3:0] fdlc,
                             input logic [63:0] fdata, input logic comp_en,
                             input logic [10:0] cid, input logic crtr,
                             input logic ack_en, input logic mid_start);
        logic [159:0] ours, comp;
        int len, ackpos, clen, cack, div, lose_at;
        build(fid, frtr, fdlc, fdata, ours, len, ackpos);
        comp = '1;
        div = -1;
        lose_at = -1;
        if (comp_en) begin
            build(cid, crtr, fdlc, fdata, comp, clen, cack);
            for (int k = 0; k < len; k++) begin
                if (ours[k] !== comp[k]) begin
                    div = k;
                    if (ours[k]) lose_at = k;
                    break;
                end
            end
        end
        id = fid; rtr = frtr; dlc = fdlc; data = fdata;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R9 lost cleared by start", lost, 0);
        check("R11 ack cleared by start", ack, 0);
        id = ~fid; rtr = ~frtr; dlc = fdlc ^ 4'h5; data = ~fdata;
        for (int k = 0; k < len; k++) begin
            other = 1'b1;
            if (comp_en && k <= div) other = comp[k];
            if (ack_en && k == ackpos) other = 1'b0;
            if (mid_start && k == 20) start = 1'b1;
            @(negedge clk); start = 1'b0;
            @(negedge clk);
            check("R2 R4 R5 R6 R7 R8 wire bit", tx, ours[k]);
            check("R2 busy during frame", busy, 1);
            tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (k == lose_at) begin
                check("R9 lost flag", lost, 1);
                check("R9 busy dropped", busy, 0);
                check("R9 tx released", tx, 1);
                check("R9 no done", done, 0);
                for (int t = 0; t < 4; t++) begin
                    other = comp[k + 1 + t];
                    @(negedge clk); tick = 1'b1;
                    @(negedge clk); tick = 1'b0;
                    check("R9 stays recessive", tx, 1);
                    check("R9 flag held", lost, 1);
                end
                other = 1'b1;
                return;
            end
        end
        check("R12 done pulse", done, 1);
        check("R12 busy dropped", busy, 0);
        check("R11 ack captured", ack, ack_en);
        check(comp_en ? "R10 no loss" : "R9 no loss", lost, 0);
        @(negedge clk);
        check("R12 done one cycle", done, 0);
        check("R3 idle recessive", tx, 1);
        other = 1'b1;
    endtask

    function automatic logic [10:0] pick_id(input int s);
        case (s)
            0: return 11'h000;
            1: return 11'h7FF;
            default: return 11'h4A5;
        endcase
    endfunction

    function automatic logic [63:0] pick_data(input int s);
        case (s)
            0: return 64'h0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            default: return 64'h0123_4567_89AB_CDEF;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset tx", tx, 1);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        check("R1 reset lost", lost, 0);
        check("R1 reset ack", ack, 0);
        for (int t = 0; t < 3; t++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
            check("R3 idle tick tx", tx, 1);
            check("R3 idle tick busy", busy, 0);
        end
        for (int s = 0; s < 3; s++)
            for (int d = 0; d < 10; d++)
                for (int r = 0; r < 2; r++)
                    run_frame(pick_id(s), r[0], d[3:0], pick_data(s), 1'b0,
                              11'h0, 1'b0, d[0], (d == 5));
        run_frame(11'h2C3, 1'b0, 4'hF, 64'hA5A5_0F0F_3C3C_8001, 1'b0, 11'h0, 1'b0, 1'b1, 1'b1);
        run_frame(11'h2C3, 1'b1, 4'hF, 64'hA5A5_0F0F_3C3C_8001, 1'b0, 11'h0, 1'b0, 1'b0, 1'b0);
        // arbitration: loss on last id bit, win, loss on remote bit, loss on first id bit
        run_frame(11'h123, 1'b0, 4'd2, 64'h55AA, 1'b1, 11'h122, 1'b0, 1'b1, 1'b0);
        run_frame(11'h123, 1'b0, 4'd2, 64'h55AA, 1'b1, 11'h124, 1'b0, 1'b1, 1'b0);
        run_frame(11'h123, 1'b1, 4'd2, 64'h55AA, 1'b1, 11'h123, 1'b0, 1'b0, 1'b0);
        run_frame(11'h7FF, 1'b0, 4'd1, 64'h0,    1'b1, 11'h000, 1'b0, 1'b0, 1'b0);
        // identical prefix that contains a stuff bit before the losing bit
        run_frame(11'h001, 1'b0, 4'd0, 64'h0,    1'b1, 11'h000, 1'b0, 1'b0, 1'b0);
        run_frame(11'h000, 1'b0, 4'd0, 64'h0,    1'b1, 11'h001, 1'b0, 1'b1, 1'b0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule